// File: doc/BRIEF.md
# IDE Channel Register Bridge

This block is the memory-mapped front end of a two-drive IDE channel. A simple bus issues single accesses of 1, 2 or 4 bytes into a 4 KiB window. The block splits that window into register slots 16 bytes apart. It checks each access size against the rules of the slot it hits. Legal data-port, taskfile and control accesses go to the IDE core through a plain request port. The core answers reads in the same cycle.

Two registers live inside the bridge itself. The first is a 32-bit timing register that software writes and reads back. The second is a 32-bit interrupt state register. Its top two bits mirror the DMA interrupt line and the disk interrupt line. Software clears the DMA bit by writing a one to it. Both interrupt lines also pass through to two separate outputs, each with a one-cycle register stage.

Register data is little-endian: a narrow read returns its value in the low bytes, zero-extended. A read that hits no register, or uses a size the slot does not allow, returns all ones. A write of that kind is dropped.

Top module: `ide_reg_bridge`

## Requirements
- R1: The slot index is busAddr[11:4]. The low four address bits do not affect decoding.
- R2: Slot 0x00 is the data port. Only 2-byte and 4-byte accesses reach the core, with coreSel = 0. A 2-byte read returns the core's low 16 bits, zero-extended.
- R3: Slots 0x01 to 0x07 are taskfile registers, 1-byte only. They reach the core with coreSel = 1 and coreReg = slot[2:0]. A read returns the core's low byte, zero-extended.
- R4: Slots 0x08 and 0x16 both map to the control register, 1-byte only, with coreSel = 2. A read returns the alternate status and a write goes to device control.
- R5: Slot 0x20 holds the timing register. A 4-byte write stores the value and a 4-byte read returns it. Writes of any other size leave it unchanged.
- R6: An access to an unmapped slot, or with a size its slot forbids, raises no coreReq. Such a read returns 0xFFFFFFFF and such a write changes nothing.
- R7: A read request produces busRvalid high for exactly one cycle, in the cycle after the request, together with busRdata. busRvalid stays low in every other cycle.
- R8: In the interrupt state register (slot 0x30, 4-byte reads), bit 31 holds the DMA line and bit 30 holds the disk line. Each bit takes the new level one cycle after its line changes. Bits 29:0 read as zero.
- R9: A 4-byte write to slot 0x30 with bit 31 set clears bit 31. Writes never change bit 30. Writes of other sizes, or with bit 31 clear, have no effect.
- R10: When the DMA line changes in the same cycle as a clearing write, the new line level wins.
- R11: dmaIrqOut and ideIrqOut equal dmaIrqIn and diskIrqIn delayed by one cycle.
- R12: After reset, the timing register and the interrupt state register are zero, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address inside the window |
| busSize | input | 3 | Access size in bytes (1, 2 or 4) |
| busWdata | input | 32 | Write data, little-endian, low-aligned |
| busRvalid | output | 1 | Read data valid pulse |
| busRdata | output | 32 | Read data |
| coreReq | output | 1 | Forwarded access to the IDE core |
| coreWrite | output | 1 | Direction of the forwarded access |
| coreSel | output | 2 | 0 data, 1 taskfile, 2 control |
| coreReg | output | 3 | Taskfile register index |
| coreSize | output | 3 | Forwarded access size in bytes |
| coreWdata | output | 32 | Forwarded write data |
| coreRdata | input | 32 | Same-cycle read answer from the core |
| dmaIrqIn | input | 1 | DMA interrupt level |
| diskIrqIn | input | 1 | Disk interrupt level |
| dmaIrqOut | output | 1 | DMA interrupt output |
| ideIrqOut | output | 1 | Disk interrupt output |

## Verification
The DMA bit of the state register has two writers: a change of the DMA line sets or clears it, and a clearing bus write resets it. Both can act in the same clock. The bench first lowers the line and clears the bit. It then raises the line in the same cycle as a 4-byte write of 0x80000000 to slot 0x30. A later read must show bit 31 set. A second case makes a clearing write coincide with a steady-high line, and the bit must read clear.

// File: rtl/ide_reg_pkg.sv
package ide_reg_pkg;
  localparam int DATA_W = 32;

  // Slot codes that the decode depends on
  localparam int SLOT_DATA   = 'h00;
  localparam int SLOT_TASKLO = 'h01;
  localparam int SLOT_TASKHI = 'h07;
  localparam int SLOT_CTLA   = 'h08;
  localparam int SLOT_CTLB   = 'h16;
  localparam int SLOT_TIMING = 'h20;
  localparam int SLOT_IRQ    = 'h30;

  typedef enum logic [1:0] {
    CORE_DATA = 2'd0,
    CORE_TASK = 2'd1,
    CORE_CTRL = 2'd2
  } coreSel_e;

  typedef enum logic [1:0] {
    SRC_ONES   = 2'd0,
    SRC_CORE   = 2'd1,
    SRC_TIMING = 2'd2,
    SRC_IRQ    = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic       rdLatch;
    rdSrc_e     rdSrc;
    logic [2:0] rdSize;
    logic       timingWr;
    logic       dmaClr;
  } strobes_t;
endpackage

// File: rtl/ide_reg_ctrl.sv
module ide_reg_ctrl
  import ide_reg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SLOT_SHIFT = 4
) (
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic              wdataTop,
  output strobes_t          strb,
  output logic              coreReq,
  output logic              coreWrite,
  output logic [1:0]        coreSel,
  output logic [2:0]        coreReg
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic [SLOT_W-1:0] slot;
  logic sz1, sz2, sz4;
  logic isData, isTask, isCtrl, isTiming, isIrq;
  logic dataOk, taskOk, ctrlOk, timOk, irqOk, coreHit;

  assign slot = busAddr[ADDR_W-1:SLOT_SHIFT];
  assign sz1  = (busSize == 3'd1);
  assign sz2  = (busSize == 3'd2);
  assign sz4  = (busSize == 3'd4);

  assign isData   = (slot == SLOT_W'(SLOT_DATA));
  assign isTask   = (slot >= SLOT_W'(SLOT_TASKLO)) && (slot <= SLOT_W'(SLOT_TASKHI));
  assign isCtrl   = (slot == SLOT_W'(SLOT_CTLA)) || (slot == SLOT_W'(SLOT_CTLB));
  assign isTiming = (slot == SLOT_W'(SLOT_TIMING));
  assign isIrq    = (slot == SLOT_W'(SLOT_IRQ));

  assign dataOk  = isData && (sz2 || sz4);
  assign taskOk  = isTask && sz1;
  assign ctrlOk  = isCtrl && sz1;
  assign timOk   = isTiming && sz4;
  assign irqOk   = isIrq && sz4;
  assign coreHit = dataOk || taskOk || ctrlOk;

  always_comb begin
    coreReq   = busReq && coreHit;
    coreWrite = busWrite;
    coreReg   = taskOk ? slot[2:0] : 3'd0;
    if (taskOk)      coreSel = CORE_TASK;
    else if (ctrlOk) coreSel = CORE_CTRL;
    else             coreSel = CORE_DATA;

    strb.rdLatch  = busReq && !busWrite;
    strb.rdSize   = busSize;
    if (coreHit)    strb.rdSrc = SRC_CORE;
    else if (timOk) strb.rdSrc = SRC_TIMING;
    else if (irqOk) strb.rdSrc = SRC_IRQ;
    else            strb.rdSrc = SRC_ONES;
    strb.timingWr = busReq && busWrite && timOk;
    strb.dmaClr   = busReq && busWrite && irqOk && wdataTop;
  end
endmodule

// File: rtl/ide_reg_dpath.sv
module ide_reg_dpath
  import ide_reg_pkg::*;
#(
  parameter int IRQ_LINES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] coreRdata,
  input  logic [IRQ_LINES-1:0] irqLines,
  output logic              busRvalid,
  output logic [DATA_W-1:0] busRdata,
  output logic [IRQ_LINES-1:0] irqOuts
);
  logic [DATA_W-1:0]    timingReg;
  logic [DATA_W-1:0]    irqState;
  logic [IRQ_LINES-1:0] irqBits;
  logic [IRQ_LINES-1:0] linePrev;
  logic [DATA_W-1:0]    rdMux;

  function automatic logic [DATA_W-1:0] fitSize(input logic [2:0] sz,
                                                input logic [DATA_W-1:0] d);
    case (sz)
      3'd1:    fitSize = {{(DATA_W-8){1'b0}}, d[7:0]};
      3'd2:    fitSize = {{(DATA_W-16){1'b0}}, d[15:0]};
      default: fitSize = d;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) timingReg <= '0;
    else if (strb.timingWr) timingReg <= busWdata;
  end

  // Line n owns state bit DATA_W-1-n; only line 0 (DMA) can be cleared
  for (genvar n = 0; n < IRQ_LINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rstN) begin
        linePrev[n] <= 1'b0;
        irqBits[n]  <= 1'b0;
        irqOuts[n]  <= 1'b0;
      end else begin
        linePrev[n] <= irqLines[n];
        irqOuts[n]  <= irqLines[n];
        if (irqLines[n] != linePrev[n]) irqBits[n] <= irqLines[n];
        else if (n == 0 && strb.dmaClr) irqBits[n] <= 1'b0;
      end
    end
    assign irqState[DATA_W-1-n] = irqBits[n];
  end
  assign irqState[DATA_W-IRQ_LINES-1:0] = '0;

  always_comb begin
    case (strb.rdSrc)
      SRC_CORE:   rdMux = fitSize(strb.rdSize, coreRdata);
      SRC_TIMING: rdMux = timingReg;
      SRC_IRQ:    rdMux = irqState;
      default:    rdMux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= strb.rdLatch;
      if (strb.rdLatch) busRdata <= rdMux;
    end
  end
endmodule

// File: rtl/ide_reg_bridge.sv
module ide_reg_bridge
  import ide_reg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SLOT_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic              busRvalid,
  output logic [31:0]       busRdata,
  output logic              coreReq,
  output logic              coreWrite,
  output logic [1:0]        coreSel,
  output logic [2:0]        coreReg,
  output logic [2:0]        coreSize,
  output logic [31:0]       coreWdata,
  input  logic [31:0]       coreRdata,
  input  logic              dmaIrqIn,
  input  logic              diskIrqIn,
  output logic              dmaIrqOut,
  output logic              ideIrqOut
);
  localparam int IRQ_LINES = 2;

  strobes_t             strb;
  logic [IRQ_LINES-1:0] outs;

  ide_reg_ctrl #(.ADDR_W(ADDR_W), .SLOT_SHIFT(SLOT_SHIFT)) u_ctrl (
    .busReq(busReq), .busWrite(busWrite), .busAddr(busAddr), .busSize(busSize),
    .wdataTop(busWdata[31]), .strb(strb), .coreReq(coreReq),
    .coreWrite(coreWrite), .coreSel(coreSel), .coreReg(coreReg)
  );

  ide_reg_dpath #(.IRQ_LINES(IRQ_LINES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .coreRdata(coreRdata), .irqLines({diskIrqIn, dmaIrqIn}),
    .busRvalid(busRvalid), .busRdata(busRdata), .irqOuts(outs)
  );

  assign coreSize  = busSize;
  assign coreWdata = busWdata;
  assign dmaIrqOut = outs[0];
  assign ideIrqOut = outs[1];
endmodule

// File: rtl/ide_reg_bridge_chk.sv
module ide_reg_bridge_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busReq,
  input logic        busWrite,
  input logic [11:0] busAddr,
  input logic [2:0]  busSize,
  input logic        busRvalid,
  input logic [31:0] busRdata,
  input logic        coreReq,
  input logic [1:0]  coreSel,
  input logic [2:0]  coreReg,
  input logic        dmaIrqIn,
  input logic        diskIrqIn,
  input logic        dmaIrqOut,
  input logic        ideIrqOut
);
  assert_rvalid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |=> busRvalid);
  assert_no_stray_rvalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(busReq && !busWrite) |=> !busRvalid);
  assert_dma_out_R11: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (dmaIrqOut == $past(dmaIrqIn)));
  assert_ide_out_R11: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (ideIrqOut == $past(diskIrqIn)));
  assert_byte_data_blocked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAddr[11:4] == 8'h00 && busSize == 3'd1) |-> !coreReq);
  assert_unmapped_ones_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && busAddr[11:4] == 8'h40) |=> (busRdata == 32'hFFFF_FFFF));
  assert_task_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && coreSel == 2'd1) |-> (coreReg == busAddr[6:4]));
endmodule

bind ide_reg_bridge ide_reg_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busRvalid(busRvalid),
  .busRdata(busRdata), .coreReq(coreReq), .coreSel(coreSel),
  .coreReg(coreReg), .dmaIrqIn(dmaIrqIn), .diskIrqIn(diskIrqIn),
  .dmaIrqOut(dmaIrqOut), .ideIrqOut(ideIrqOut)
);

// File: tb/ide_reg_bridge_bench.sv
`timescale 1ns/1ps
module ide_reg_bridge_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [2:0]  busSize = 3'd4;
  logic [31:0] busWdata = '0;
  logic        busRvalid;
  logic [31:0] busRdata;
  logic        coreReq, coreWrite;
  logic [1:0]  coreSel;
  logic [2:0]  coreReg, coreSize;
  logic [31:0] coreWdata, coreRdata;
  logic        dmaIrqIn = 1'b0, diskIrqIn = 1'b0;
  logic        dmaIrqOut, ideIrqOut;

  int errors = 0;
  int checks = 0;
  logic [31:0] timingExp = '0;

  always #2.5 clk = ~clk;

  // Core model: answer encodes select and register index
  assign coreRdata = {16'hC0DE, 8'h5A, coreSel, 3'b000, coreReg};

  ide_reg_bridge u_ide_reg_bridge (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] coreAns(input int slot);
    logic [1:0] sel;
    logic [2:0] rg;
    sel = (slot == 0) ? 2'd0 : (slot <= 7) ? 2'd1 : 2'd2;
    rg  = (slot >= 1 && slot <= 7) ? 3'(slot) : 3'd0;
    return {16'hC0DE, 8'h5A, sel, 3'b000, rg};
  endfunction

  function automatic bit coreLegal(input int slot, input int sz);
    if (slot == 0) return (sz == 2 || sz == 4);
    if (slot >= 1 && slot <= 7) return sz == 1;
    if (slot == 8 || slot == 'h16) return sz == 1;
    return 0;
  endfunction

  task automatic doRead(input int slot, input int sz, input int lo, output logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b0; busAddr = 12'((slot << 4) | lo); busSize = 3'(sz);
    @(negedge clk);
    busReq = 1'b0;
    chk("R7 valid", {31'b0, busRvalid}, 32'd1);
    d = busRdata;
    @(negedge clk);
    chk("R7 single", {31'b0, busRvalid}, 32'd0);
  endtask

  task automatic doWrite(input int slot, input int sz, input logic [31:0] v);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = 12'(slot << 4); busSize = 3'(sz); busWdata = v;
    #1;
    chk("R6 core request gate", {31'b0, coreReq}, {31'b0, coreLegal(slot, sz)});
    @(negedge clk);
    busReq = 1'b0;
  endtask

  initial begin : watchdog
    #900000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    chk("R12 dma out", {31'b0, dmaIrqOut}, 32'd0);
    chk("R12 ide out", {31'b0, ideIrqOut}, 32'd0);
    doRead('h20, 4, 0, d); chk("R12 timing", d, 32'd0);
    doRead('h30, 4, 0, d); chk("R12 irq", d, 32'd0);

    // Read sweep over all slots and sizes (R1..R6)
    for (int s = 0; s < 256; s++) begin
      for (int z = 1; z <= 4; z++) begin
        if (z == 3) continue;
        doRead(s, z, (s * 7) & 15, d);
        if (coreLegal(s, z)) begin
          e = coreAns(s);
          if (z == 1) e = {24'h0, e[7:0]};
          else if (z == 2) e = {16'h0, e[15:0]};
        end else if ((s == 'h20 || s == 'h30) && z == 4) e = 32'd0;
        else e = 32'hFFFF_FFFF;
        if (s == 0) chk("R2 data read", d, e);
        else if (s <= 7) chk("R3 taskfile read", d, e);
        else if (s == 8 || s == 'h16) chk("R4 control read", d, e);
        else if (e == 32'hFFFF_FFFF) chk("R6 unmapped or bad size ones", d, e);
        else chk("R1 local register read", d, e);
      end
    end

    // Write sweep: core gating, forwarded fields, timing storage (R5, R6)
    for (int s = 0; s < 256; s++) begin
      for (int z = 1; z <= 4; z++) begin
        if (z == 3 || s == 'h30) continue;
        doWrite(s, z, 32'h1234_5600 ^ 32'(s) ^ (32'(z) << 12));
        if (s == 'h20 && z == 4) timingExp = 32'h1234_5600 ^ 32'(s) ^ (32'(z) << 12);
      end
    end
    doRead('h20, 4, 0, d); chk("R5 timing after sweep", d, timingExp);
    doWrite('h20, 2, 32'hDEAD_BEEF);
    doRead('h20, 4, 0, d); chk("R5 narrow write ignored", d, timingExp);
    doWrite('h20, 4, 32'hA5A5_0F0F);
    doRead('h20, 4, 3, d); chk("R5 stored", d, 32'hA5A5_0F0F);

    // Forwarded write fields on a taskfile access (R3)
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = 12'h05C; busSize = 3'd1; busWdata = 32'h0000_0077;
    #1;
    chk("R3 coreSel", {30'b0, coreSel}, 32'd1);
    chk("R3 coreReg", {29'b0, coreReg}, 32'd5);
    chk("R3 coreWdata", coreWdata, 32'h77);
    chk("R3 coreWrite", {31'b0, coreWrite}, 32'd1);
    @(negedge clk); busReq = 1'b0;

    // Interrupts (R8, R9, R10, R11)
    @(negedge clk); dmaIrqIn = 1'b1;
    @(negedge clk);
    chk("R11 dma out", {31'b0, dmaIrqOut}, 32'd1);
    doRead('h30, 4, 0, d); chk("R8 dma bit", d, 32'h8000_0000);
    doWrite('h30, 2, 32'h8000_0000);
    doRead('h30, 4, 0, d); chk("R9 narrow clear ignored", d, 32'h8000_0000);
    doWrite('h30, 4, 32'h7FFF_FFFF);
    doRead('h30, 4, 0, d); chk("R9 bit31 clear needed", d, 32'h8000_0000);
    doWrite('h30, 4, 32'h8000_0000);
    doRead('h30, 4, 0, d); chk("R9 cleared while line high", d, 32'h0);
    chk("R11 dma out held", {31'b0, dmaIrqOut}, 32'd1);
    @(negedge clk); diskIrqIn = 1'b1;
    @(negedge clk);
    chk("R11 ide out", {31'b0, ideIrqOut}, 32'd1);
    doWrite('h30, 4, 32'hFFFF_FFFF);
    doRead('h30, 4, 0, d); chk("R9 disk bit kept", d, 32'h4000_0000);
    @(negedge clk); dmaIrqIn = 1'b0; diskIrqIn = 1'b0;
    @(negedge clk);
    doRead('h30, 4, 0, d); chk("R8 both low", d, 32'h0);
    // Coincident line rise and clearing write
    @(negedge clk);
    dmaIrqIn = 1'b1;
    busReq = 1'b1; busWrite = 1'b1; busAddr = 12'h300; busSize = 3'd4; busWdata = 32'h8000_0000;
    @(negedge clk); busReq = 1'b0;
    doRead('h30, 4, 0, d); chk("R10 rise beats clear", d, 32'h8000_0000);
    @(negedge clk); dmaIrqIn = 1'b0;
    @(negedge clk);
    doRead('h30, 4, 0, d); chk("R8 fall clears bit", d, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule